// File: doc/BRIEF.md
# Flash Page Program Sequencer

This block drives an external parallel flash over a simple single-cycle bus master port so that a host can program pages of it. A start pulse makes it write the three-word unlock/program command. It then passes address/data pairs from a valid/ready stream straight onto the bus until the word marked last. After that it waits a fixed number of clock cycles and polls the flash status word until the device reports ready. It ends with a one-cycle done or fail pulse.

To program further pages the host pulses start again. Each page repeats the full command prologue. After the final page nothing more is issued, so the device stays in status-read mode. A failure, whether a program error or too many polls, sets a sticky clear-needed flag. While that flag is set every start is refused. A clear request writes one clear-status command word and drops the flag. Bus writes take effect in the cycle that `bus_we` is high. A status read issued with `bus_re` in one cycle returns its word on `bus_rdata` in the next cycle.

Top module: `flash_page_prog`

## Requirements
- R1: After reset `busy`, `done`, `fail`, `clr_need`, `bus_we`, `bus_re` and `dat_ready` are all 0.
- R2: An accepted start produces exactly three bus writes in consecutive cycles: data AAh at address 5555h, then 55h at 2AAAh, then A0h at 5555h.
- R3: After the prologue, `dat_ready` is 1. Each word taken with `dat_valid`&`dat_ready` is written on the bus in that cycle with its own address and data. The word with `dat_last` ends loading. `bus_we` and `bus_re` are never high together.
- R4: The first status read (`bus_re`) comes WAIT_CYC+1 cycles after the cycle of the last data write.
- R5: A status word with bit 7 = 0 causes another status read two cycles after the previous one.
- R6: A status word with bit 7 = 1 and bit 4 = 0 gives a one-cycle `done` pulse, after which `busy` is 0.
- R7: A status word with bit 7 = 1 and bit 4 = 1 gives a one-cycle `fail` pulse with `fail_tmo` = 0 and sets `clr_need`.
- R8: If MAX_POLLS status reads all show bit 7 = 0, the block gives a `fail` pulse with `fail_tmo` = 1 and sets `clr_need`. No further read is issued.
- R9: `busy` is 1 from the cycle after an accepted start until the done or fail pulse. A start pulse while busy issues no extra bus write.
- R10: While `clr_need` is 1, start is ignored: no bus write and `busy` stays 0. A `clr_req` then writes CLR_CMD at CLR_ADDR in that same cycle and clears `clr_need` on the next cycle.
- R11: A start after a successful page programs another page, repeating the full three-write prologue.
- R12: A `clr_req` while `clr_need` is 0 produces no bus write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one page operation |
| clr_req | input | 1 | Request the clear-status command |
| dat_valid | input | 1 | Page word available |
| dat_last | input | 1 | Current word is the last of the page |
| dat_addr | input | ADDR_W | Flash address of the page word |
| dat_data | input | DATA_W | Data of the page word |
| dat_ready | output | 1 | Sequencer takes a page word this cycle |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_we | output | 1 | Bus write strobe |
| bus_re | output | 1 | Bus read strobe |
| bus_rdata | input | DATA_W | Read data, valid the cycle after `bus_re` |
| busy | output | 1 | Page operation in progress |
| done | output | 1 | One-cycle success pulse |
| fail | output | 1 | One-cycle failure pulse |
| fail_tmo | output | 1 | Cause of the last failure: 1 = poll timeout |
| clr_need | output | 1 | Clear-status command outstanding |

## Verification
Some properties are checked by assertions on every cycle. Write and read strobes never overlap, and the page stream is only accepted while busy. Done and fail are exclusive single-cycle pulses, and each failure raises the clear flag. The settle interval measures exactly WAIT_CYC cycles, and a served clear request drops the flag. The bench scenarios show the rest: the exact address/data order of the prologue and page words, and the poll count for each ready delay. They also show how the timeout and program-error outcomes differ, that starts are refused while a clear is outstanding, and that the prologue is repeated for a second page.

// File: rtl/fpp_pkg.sv
package fpp_pkg;

    localparam logic [15:0] UNLK_ADDR_A = 16'h5555;
    localparam logic [15:0] UNLK_ADDR_B = 16'h2AAA;
    localparam logic [7:0]  UNLK_KEY_A  = 8'hAA;
    localparam logic [7:0]  UNLK_KEY_B  = 8'h55;
    localparam logic [7:0]  PGM_OPCODE  = 8'hA0;

    localparam int RDY_BIT  = 7;
    localparam int PERR_BIT = 4;

    typedef enum logic [2:0] {
        ST_IDLE, ST_KEY1, ST_KEY2, ST_OPC,
        ST_LOAD, ST_SETTLE, ST_RDSTAT, ST_CHKSTAT
    } seq_state_t;

    typedef enum logic [1:0] {
        POLL_PENDING, POLL_PASS, POLL_PGMERR, POLL_TMO
    } poll_res_t;

    typedef struct packed {
        logic [15:0] addr;
        logic [7:0]  data;
    } cmd_word_t;

    function automatic cmd_word_t prologue_word(seq_state_t s);
        cmd_word_t w;
        case (s)
            ST_KEY1: w = '{addr: UNLK_ADDR_A, data: UNLK_KEY_A};
            ST_KEY2: w = '{addr: UNLK_ADDR_B, data: UNLK_KEY_B};
            default: w = '{addr: UNLK_ADDR_A, data: PGM_OPCODE};
        endcase
        return w;
    endfunction

endpackage

// File: rtl/fpp_countdown.sv
module fpp_countdown #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                   cnt <= '0;
        else if (load)             cnt <= load_val;
        else if (dec && cnt != '0) cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/fpp_status_decode.sv
module fpp_status_decode
    import fpp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] rdata,
    input  logic              last_poll,
    output poll_res_t         res
);
    logic unused_bits;
    assign unused_bits = ^rdata;

    always_comb begin
        if (rdata[RDY_BIT])       res = rdata[PERR_BIT] ? POLL_PGMERR : POLL_PASS;
        else if (last_poll)       res = POLL_TMO;
        else                      res = POLL_PENDING;
    end
endmodule

// File: rtl/flash_page_prog.sv
module flash_page_prog
    import fpp_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter int              DATA_W    = 8,
    parameter int              WAIT_CYC  = 20000,
    parameter int              MAX_POLLS = 64,
    parameter logic [15:0]     STAT_ADDR = 16'h0000,
    parameter logic [15:0]     CLR_ADDR  = 16'h5555,
    parameter logic [7:0]      CLR_CMD   = 8'h50
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              clr_req,
    input  logic              dat_valid,
    input  logic              dat_last,
    input  logic [ADDR_W-1:0] dat_addr,
    input  logic [DATA_W-1:0] dat_data,
    output logic              dat_ready,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_we,
    output logic              bus_re,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic              fail_tmo,
    output logic              clr_need
);
    localparam int WT_W = $clog2(WAIT_CYC + 1);
    localparam int PL_W = $clog2(MAX_POLLS + 1);
    localparam logic [WT_W-1:0] WT_LOAD = WT_W'(WAIT_CYC - 1);
    localparam logic [PL_W-1:0] PL_LOAD = PL_W'(MAX_POLLS - 1);

    seq_state_t state;
    poll_res_t  res;
    cmd_word_t  pw;
    logic       wait_zero, poll_zero, wait_load, clr_fire;

    assign wait_load = (state == ST_LOAD) && dat_valid && dat_last;
    assign clr_fire  = (state == ST_IDLE) && clr_need && clr_req;

    fpp_countdown #(.W(WT_W)) u_settle (
        .clk(clk), .rst(rst), .load(wait_load), .load_val(WT_LOAD),
        .dec(state == ST_SETTLE), .zero(wait_zero)
    );

    fpp_countdown #(.W(PL_W)) u_polls (
        .clk(clk), .rst(rst), .load(state == ST_SETTLE), .load_val(PL_LOAD),
        .dec(state == ST_CHKSTAT), .zero(poll_zero)
    );

    fpp_status_decode #(.DATA_W(DATA_W)) u_decode (
        .rdata(bus_rdata), .last_poll(poll_zero), .res(res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            done     <= 1'b0;
            fail     <= 1'b0;
            fail_tmo <= 1'b0;
            clr_need <= 1'b0;
        end else begin
            done <= 1'b0;
            fail <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (clr_fire)                   clr_need <= 1'b0;
                    else if (start && !clr_need)    state    <= ST_KEY1;
                end
                ST_KEY1:   state <= ST_KEY2;
                ST_KEY2:   state <= ST_OPC;
                ST_OPC:    state <= ST_LOAD;
                ST_LOAD:   if (wait_load) state <= ST_SETTLE;
                ST_SETTLE: if (wait_zero) state <= ST_RDSTAT;
                ST_RDSTAT: state <= ST_CHKSTAT;
                ST_CHKSTAT: begin
                    case (res)
                        POLL_PENDING: state <= ST_RDSTAT;
                        POLL_PASS: begin
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end
                        default: begin
                            fail     <= 1'b1;
                            fail_tmo <= (res == POLL_TMO);
                            clr_need <= 1'b1;
                            state    <= ST_IDLE;
                        end
                    endcase
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (state != ST_IDLE);
    assign dat_ready = (state == ST_LOAD);
    assign pw        = prologue_word(state);

    always_comb begin
        bus_we    = 1'b0;
        bus_re    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        case (state)
            ST_IDLE: if (clr_fire) begin
                bus_we    = 1'b1;
                bus_addr  = ADDR_W'(CLR_ADDR);
                bus_wdata = DATA_W'(CLR_CMD);
            end
            ST_KEY1, ST_KEY2, ST_OPC: begin
                bus_we    = 1'b1;
                bus_addr  = ADDR_W'(pw.addr);
                bus_wdata = DATA_W'(pw.data);
            end
            ST_LOAD: begin
                bus_we    = dat_valid;
                bus_addr  = dat_addr;
                bus_wdata = dat_data;
            end
            ST_RDSTAT: begin
                bus_re   = 1'b1;
                bus_addr = ADDR_W'(STAT_ADDR);
            end
            default: ;
        endcase
    end

    // Checker: length of the settle interval, measured independently
    int chk_settle;
    always_ff @(posedge clk) begin
        if (rst || state != ST_SETTLE) chk_settle <= 0;
        else                           chk_settle <= chk_settle + 1;
    end

    assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && bus_re));
    assert_ready_busy_R3: assert property (@(posedge clk) disable iff (rst)
        dat_ready |-> busy);
    assert_settle_len_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RDSTAT && $past(state) == ST_SETTLE) |-> chk_settle == WAIT_CYC);
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_done_fail_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(done && fail));
    assert_fail_flags_R7: assert property (@(posedge clk) disable iff (rst)
        fail |-> clr_need);
    assert_busy_start_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && !clr_need && !clr_req) |=> busy);
    assert_clr_drop_R10: assert property (@(posedge clk) disable iff (rst)
        (!busy && clr_need && clr_req) |=> !clr_need);
endmodule

// File: tb/flash_page_prog_bench.sv
module flash_page_prog_bench;
    localparam int ADDR_W = 16, DATA_W = 8, WAIT_CYC = 8, MAX_POLLS = 4;

    logic clk = 0, rst = 1, start = 0, clr_req = 0;
    logic dat_valid = 0, dat_last = 0;
    logic [ADDR_W-1:0] dat_addr = '0;
    logic [DATA_W-1:0] dat_data = '0;
    logic dat_ready, bus_we, bus_re, busy, done, fail, fail_tmo, clr_need;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_wdata, bus_rdata;

    always #2.5 clk = ~clk;

    flash_page_prog #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_CYC(WAIT_CYC),
        .MAX_POLLS(MAX_POLLS), .STAT_ADDR(16'h0000), .CLR_ADDR(16'h5555),
        .CLR_CMD(8'h50)) u_flash_page_prog (
        .clk(clk), .rst(rst), .start(start), .clr_req(clr_req),
        .dat_valid(dat_valid), .dat_last(dat_last), .dat_addr(dat_addr),
        .dat_data(dat_data), .dat_ready(dat_ready), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
        .bus_rdata(bus_rdata), .busy(busy), .done(done), .fail(fail),
        .fail_tmo(fail_tmo), .clr_need(clr_need));

    int checks = 0, errors = 0;
    int cyc = 0, wn = 0, rn = 0, rfirst = 0, rlast = 0, rgap_bad = 0;
    int done_cnt = 0, fail_cnt = 0, ready_after = 0, last_tmo = 0;
    logic err_bit = 0;
    logic [ADDR_W-1:0] wa [64];
    logic [DATA_W-1:0] wd [64];
    int wc [64];

    // Monitor and flash model
    always @(posedge clk) begin
        if (bus_we && wn < 64) begin
            wa[wn] = bus_addr; wd[wn] = bus_wdata; wc[wn] = cyc;
            wn = wn + 1;
        end
        if (bus_re) begin
            if (rn == 0) rfirst = cyc;
            else if (cyc - rlast != 2) rgap_bad = rgap_bad + 1;
            rlast = cyc;
            bus_rdata <= (rn >= ready_after) ? {1'b1, 2'b00, err_bit, 4'b0000} : 8'h00;
            rn = rn + 1;
        end
        if (done) done_cnt = done_cnt + 1;
        if (fail) begin fail_cnt = fail_cnt + 1; last_tmo = fail_tmo; end
        cyc = cyc + 1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clear_logs();
        wn = 0; rn = 0; rgap_bad = 0;
    endtask

    // One page: n words, status ready after ra not-ready reads
    task automatic run_page(input int page, input int n, input int ra, input logic eb,
                            input bit poke_start);
        int d0, f0, k, last_w;
        clear_logs();
        ready_after = ra; err_bit = eb;
        d0 = done_cnt; f0 = fail_cnt;
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        chk(busy == 1, "R9 busy after start", busy, 1);
        for (int i = 0; i < n; i++) begin
            if (i == 1) begin @(negedge clk); dat_valid = 0; end
            @(negedge clk);
            dat_valid = 1; dat_last = (i == n - 1);
            dat_addr = 16'h1000 + 16'(page * 16 + i);
            dat_data = 8'(i * 37 + page * 5 + 1);
            #1;
            while (!dat_ready) begin @(negedge clk); #1; end
        end
        @(negedge clk); dat_valid = 0; dat_last = 0;
        if (poke_start) begin start = 1; @(negedge clk); start = 0; end
        k = 0;
        while (done_cnt == d0 && fail_cnt == f0 && k < 400) begin @(negedge clk); k++; end
        chk(wn == 3 + n, "R9 write count (no extra prologue)", wn, 3 + n);
        chk(wa[0] == 16'h5555 && wd[0] == 8'hAA, "R2 first prologue write", int'(wd[0]), 'hAA);
        chk(wa[1] == 16'h2AAA && wd[1] == 8'h55, "R2 second prologue write", int'(wd[1]), 'h55);
        chk(wa[2] == 16'h5555 && wd[2] == 8'hA0, "R2 third prologue write", int'(wd[2]), 'hA0);
        chk(wc[1] == wc[0] + 1 && wc[2] == wc[1] + 1 && wc[3] == wc[2] + 1,
            "R2 consecutive prologue", wc[2] - wc[0], 2);
        for (int i = 0; i < n; i++)
            chk(wa[3+i] == 16'h1000 + 16'(page * 16 + i) && wd[3+i] == 8'(i * 37 + page * 5 + 1),
                "R3 page word", int'(wd[3+i]), int'(8'(i * 37 + page * 5 + 1)));
        last_w = wc[2 + n];
        chk(rfirst - last_w == WAIT_CYC + 1, "R4 settle to first read", rfirst - last_w, WAIT_CYC + 1);
        chk(rgap_bad == 0, "R5 poll spacing", rgap_bad, 0);
        chk(busy == 0, "R9 busy low after end", busy, 0);
        if (ra < MAX_POLLS) begin
            chk(rn == ra + 1, "R5 poll count", rn, ra + 1);
            if (!eb) begin
                chk(done_cnt == d0 + 1 && fail_cnt == f0, "R6 done pulse", done_cnt - d0, 1);
                chk(clr_need == 0, "R6 no clear needed", clr_need, 0);
            end else begin
                chk(fail_cnt == f0 + 1 && done_cnt == d0, "R7 fail pulse", fail_cnt - f0, 1);
                chk(last_tmo == 0, "R7 fail cause", last_tmo, 0);
                chk(clr_need == 1, "R7 clear needed", clr_need, 1);
            end
        end else begin
            chk(rn == MAX_POLLS, "R8 poll limit", rn, MAX_POLLS);
            chk(fail_cnt == f0 + 1 && done_cnt == d0, "R8 fail pulse", fail_cnt - f0, 1);
            chk(last_tmo == 1, "R8 timeout cause", last_tmo, 1);
            chk(clr_need == 1, "R8 clear needed", clr_need, 1);
        end
    endtask

    task automatic do_clear();
        clear_logs();
        @(negedge clk); clr_req = 1;
        @(negedge clk); clr_req = 0;
        chk(wn == 1 && wa[0] == 16'h5555 && wd[0] == 8'h50, "R10 clear command write",
            int'(wd[0]), 'h50);
        chk(clr_need == 0, "R10 clear flag drops", clr_need, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && fail == 0 && clr_need == 0 &&
            bus_we == 0 && bus_re == 0 && dat_ready == 0, "R1 reset state", busy, 0);
        rst = 0;
        @(negedge clk);
        chk(busy == 0 && bus_we == 0 && bus_re == 0, "R1 idle after reset", bus_we, 0);

        run_page(0, 4, 2, 0, 1);
        run_page(1, 1, 0, 0, 0);   // R11 second page repeats prologue
        chk(done_cnt == 2, "R11 two pages done", done_cnt, 2);

        clear_logs();              // R12 clear request without pending error
        @(negedge clk); clr_req = 1;
        @(negedge clk); clr_req = 0;
        chk(wn == 0, "R12 clear ignored", wn, 0);

        run_page(2, 2, 1, 1, 0);   // program error
        clear_logs();              // R10 start refused while clear needed
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        repeat (4) @(negedge clk);
        chk(wn == 0 && busy == 0, "R10 start refused", wn, 0);
        do_clear();

        run_page(3, 3, 100, 0, 0); // timeout
        do_clear();

        for (int n = 1; n <= 3; n++)
            for (int ra = 0; ra <= MAX_POLLS; ra++) begin
                run_page(4 + n, n, ra, 1'(ra % 2), ra == 1);
                if (clr_need) do_clear();
            end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule